// File: doc/BRIEF.md
# SPI Target Register Bridge

This block lets an external host reach a 32-bit internal register bus through a four-wire serial link in clock mode 0. The target samples MOSI on rising SCK edges and changes MISO only after falling SCK edges. Every frame opens with a 24-bit command word. A write then carries one 32-bit data word. A read carries a programmable number of idle padding bytes, after which the target shifts one 32-bit word back out. The padding gives a slow internal access time to finish before its first data bit is needed.

The serial pins are brought into a faster system clock through flop synchronizers, and edges are detected there. Two local registers live inside the bridge and never reach the internal bus. The format register selects the byte order and the bit order of the data payload. The configuration/status register holds the padding count, a sticky flag for reads that came out too early, and a fixed code that identifies the serial interface. Every other address becomes a single-cycle request on the internal bus, whose acknowledge arrives after a fixed latency.

Top module: `spi_regbridge`

## Requirements
- R1: The command is the first 24 bits of a frame, sent most significant bit first under every payload format. Bit 23 is 1 for a write and 0 for a read, and bits 22:0 are a word address (byte address divided by 4). A non-local access produces exactly one single-cycle `bus_req` carrying that address, with `bus_we` equal to the write bit.
- R2: On a write, the 32 bits after the command are decoded under the current format. They are issued once to the bus or the addressed local register, and only after bit 56 of the frame has arrived.
- R3: On a read with padding count N, the first data bit appears on MISO after the falling SCK edge that follows rising edge 24+8N. Each later falling edge presents the next bit, and MISO does not change while SCK stays high.
- R4: Format bit 0 set means the most significant byte goes first (clear: least significant first). Format bit 1 set means bit 0 of each byte goes first (clear: bit 7 first). So 00 = little-endian MSB-first, 01 = big-endian MSB-first, 10 = little-endian LSB-first, 11 = big-endian LSB-first.
- R5: The format register is at word address LOCAL_BASE and reads back as the format in bits 1:0 with zeros above. A write to it is decoded under the format in force at that moment and affects later frames. A word that repeats the format bits as bits 7/0 = f[0] and 6/1 = f[1] in every byte decodes the same under all four formats.
- R6: The configuration/status register is at LOCAL_BASE+1. It reads back as: bits 3:0 the padding count, bit 16 the late flag, bits 31:24 the interface code 2, and all other bits 0. Writing it loads the padding count from bits 3:0.
- R7: If the read data is not ready when its first bit must be driven, the target shifts out 32 zero bits and sets the late flag. The flag stays set until the next write to the configuration/status register, which clears it.
- R8: Releasing chip select before the last data bit of a write makes no bus request and leaves every register unchanged. The next frame is decoded from its first bit.
- R9: Reset sets the format to 00, the padding count to 0 and the late flag to 0, and drives `spi_miso` and `bus_req` low.
- R10: A read of a local register produces no `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_req | output | 1 | One-cycle request on the internal bus |
| bus_we | output | 1 | 1 = write request, 0 = read request |
| bus_addr | output | 23 | Word address of the request |
| bus_wdata | output | 32 | Write data of the request |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle completion of the request |

## Verification
The bench builds the block with LOCAL_BASE at 0 and two synchronizer stages. It runs SCK at sixteen system cycles per bit against a bus model that answers forty cycles after each request. With those numbers a read with zero padding is always late and a read with one or more padding bytes never is, so the late flag can be predicted exactly. Each of the four payload formats is swept with several data words. Bus-side words and raw MISO bit streams are compared with an arithmetic encoding of each word, and aborted frames and a mid-run reset are also covered.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int WORD_W = 32;
    localparam int CMD_W  = 24;
    localparam int ADDR_W = CMD_W - 1;
    localparam int PAD_W  = 4;
    localparam int CNT_W  = 8;
    localparam int BYTE_W = 8;
    localparam logic [7:0] IF_CODE_SERIAL = 8'd2;

    typedef enum logic [1:0] {
        FMT_LE_MSB = 2'b00,
        FMT_BE_MSB = 2'b01,
        FMT_LE_LSB = 2'b10,
        FMT_BE_LSB = 2'b11
    } fmt_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [7:0]       if_code;
        logic [6:0]       zero_hi;
        logic             late;
        logic [11:0]      zero_lo;
        logic [PAD_W-1:0] pad;
    } cfgstat_t;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_WDATA,
        PH_RPAD,
        PH_RDATA,
        PH_DONE
    } phase_e;

    // word bit that travels at wire position k (k = 0 is first on the wire)
    function automatic int wire_src(input fmt_e f, input int k);
        int byte_i;
        int bit_i;
        byte_i = f[0] ? (3 - k / BYTE_W) : (k / BYTE_W);
        bit_i  = f[1] ? (k % BYTE_W) : (BYTE_W - 1 - k % BYTE_W);
        return byte_i * BYTE_W + bit_i;
    endfunction

    // word -> stream sent MSB first
    function automatic logic [WORD_W-1:0] to_wire(input fmt_e f, input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < WORD_W; k++) begin
            r[WORD_W-1-k] = w[wire_src(f, k)];
        end
        return r;
    endfunction

    // stream received MSB first -> word
    function automatic logic [WORD_W-1:0] from_wire(input fmt_e f, input logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < WORD_W; k++) begin
            r[wire_src(f, k)] = s[WORD_W-1-k];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  fmt_e              fmt,
    input  logic [PAD_W-1:0]  pad_n,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              rd_ready,
    output cmd_t              cmd,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    output logic              late_evt,
    output logic              miso
);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(CMD_W + WORD_W - 1);

    logic              sck_q;
    logic              rise, fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] sh_in;
    logic [WORD_W-1:0] sh_out;
    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  rd_start;
    phase_e            phase;

    assign rise      = sck_s & ~sck_q;
    assign fall      = ~sck_s & sck_q;
    assign in_word   = {sh_in[WORD_W-2:0], mosi_s};
    assign rd_start  = CNT_W'(CMD_W) + CNT_W'({pad_n, 3'b000});
    assign load_word = rd_ready ? to_wire(fmt, rd_word) : '0;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    always_ff @(posedge clk) begin
        cmd_valid <= 1'b0;
        wr_valid  <= 1'b0;
        late_evt  <= 1'b0;
        if (rst) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            miso    <= 1'b0;
            cmd     <= '0;
            wr_data <= '0;
        end else if (cs_n_s) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            sh_out  <= '0;
            miso    <= 1'b0;
        end else if (rise) begin
            sh_in <= in_word;
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            if (phase == PH_CMD && bit_cnt == CMD_LAST) begin
                cmd       <= cmd_t'(in_word[CMD_W-1:0]);
                cmd_valid <= 1'b1;
                phase     <= in_word[CMD_W-1] ? PH_WDATA : PH_RPAD;
            end else if (phase == PH_WDATA && bit_cnt == WR_LAST) begin
                wr_data  <= from_wire(fmt, in_word);
                wr_valid <= 1'b1;
                phase    <= PH_DONE;
            end
        end else if (fall) begin
            if (phase == PH_RPAD && bit_cnt == rd_start) begin
                sh_out   <= {load_word[WORD_W-2:0], 1'b0};
                miso     <= load_word[WORD_W-1];
                late_evt <= ~rd_ready;
                phase    <= PH_RDATA;
            end else if (phase == PH_RDATA) begin
                sh_out <= {sh_out[WORD_W-2:0], 1'b0};
                miso   <= sh_out[WORD_W-1];
            end
        end
    end

    // R3: MISO holds while SCK stays high inside a frame
    a_r3_miso_hold_high: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cs_n_s && !$past(cs_n_s) && sck_s && sck_q) |-> $stable(miso));

    // R8: a released select returns the frame engine to its start
    a_r8_idle_on_release: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (phase == PH_CMD && bit_cnt == '0));
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
    import spi_rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCAL_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              late_evt,
    output fmt_e              fmt,
    output logic [PAD_W-1:0]  pad_n,
    output logic              local_hit,
    output logic [WORD_W-1:0] local_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_FMT = LOCAL_BASE;
    localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(LOCAL_BASE + 1'b1);

    logic     hit_fmt, hit_cfg;
    logic     late_flag;
    logic     cfg_wr;
    cfgstat_t cfg_view;

    assign hit_fmt   = (cmd.addr == ADDR_FMT);
    assign hit_cfg   = (cmd.addr == ADDR_CFG);
    assign local_hit = hit_fmt | hit_cfg;
    assign cfg_wr    = wr_valid & hit_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt       <= FMT_LE_MSB;
            pad_n     <= '0;
            late_flag <= 1'b0;
        end else begin
            if (wr_valid && hit_fmt) fmt <= fmt_e'(wr_data[1:0]);
            if (cfg_wr) begin
                pad_n     <= wr_data[PAD_W-1:0];
                late_flag <= 1'b0;
            end else if (late_evt) begin
                late_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg_view         = '0;
        cfg_view.if_code = IF_CODE_SERIAL;
        cfg_view.late    = late_flag;
        cfg_view.pad     = pad_n;
        local_rdata      = hit_fmt ? {{(WORD_W-2){1'b0}}, fmt} : cfg_view;
    end

    // R7: the late flag is sticky until a status register write
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (late_flag && !cfg_wr) |=> late_flag);

    // R7: a late load always raises the flag
    a_r7_late_sets_flag: assert property (@(posedge clk) disable iff (rst)
        late_evt |=> late_flag);
endmodule

// File: rtl/spi_rb_busif.sv
module spi_rb_busif
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              cmd_valid,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              local_hit,
    input  logic [WORD_W-1:0] local_rdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_ready
);
    logic rd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_word   <= '0;
            rd_ready  <= 1'b0;
            rd_pend   <= 1'b0;
        end else begin
            bus_req <= 1'b0;
            if (cmd_valid && !cmd.wr) begin
                if (local_hit) begin
                    rd_word  <= local_rdata;
                    rd_ready <= 1'b1;
                end else begin
                    bus_req  <= 1'b1;
                    bus_we   <= 1'b0;
                    bus_addr <= cmd.addr;
                    rd_ready <= 1'b0;
                    rd_pend  <= 1'b1;
                end
            end else if (wr_valid && !local_hit) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= cmd.addr;
                bus_wdata <= wr_data;
            end
            if (bus_ack && rd_pend) begin
                rd_word  <= bus_rdata;
                rd_ready <= 1'b1;
                rd_pend  <= 1'b0;
            end
        end
    end

    // R1: every bus request lasts exactly one cycle
    a_r1_req_single: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> !bus_req);

    // R10: local accesses never reach the internal bus
    a_r10_local_no_bus: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && local_hit) |=> !bus_req);
endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
    import spi_rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCAL_BASE  = '0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_n_s, mosi_s;
    fmt_e              fmt;
    logic [PAD_W-1:0]  pad_n;
    cmd_t              cmd;
    logic              cmd_valid, wr_valid, late_evt;
    logic [WORD_W-1:0] wr_data, rd_word, local_rdata;
    logic              rd_ready, local_hit;

    spi_rb_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sck, spi_cs_n, spi_mosi}),
        .q  (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_rb_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .fmt      (fmt),
        .pad_n    (pad_n),
        .rd_word  (rd_word),
        .rd_ready (rd_ready),
        .cmd      (cmd),
        .cmd_valid(cmd_valid),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .late_evt (late_evt),
        .miso     (spi_miso)
    );

    spi_rb_regs #(
        .LOCAL_BASE(LOCAL_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .late_evt   (late_evt),
        .fmt        (fmt),
        .pad_n      (pad_n),
        .local_hit  (local_hit),
        .local_rdata(local_rdata)
    );

    spi_rb_busif u_busif (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .cmd_valid  (cmd_valid),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .local_hit  (local_hit),
        .local_rdata(local_rdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_word    (rd_word),
        .rd_ready   (rd_ready)
    );
endmodule

// File: tb/spi_regbridge_tb.sv
module spi_regbridge_tb;
    localparam int H   = 8;
    localparam int LAT = 40;
    localparam logic [22:0] BASE = 23'h0;
    localparam logic [22:0] CFG  = 23'h1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        bus_req, bus_we;
    logic [22:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    logic [22:0] last_addr;
    logic        last_we;
    logic [1:0]  cur_fmt = 2'b00;
    int          cur_pad = 0;
    logic        done = 1'b0;

    logic [31:0] mem [16];
    int          lat_cnt;
    logic        busy;
    logic [22:0] p_addr;
    logic        p_we;
    logic [31:0] p_wd;

    always #5 clk = ~clk;

    spi_regbridge #(.LOCAL_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // register file model with a fixed latency
    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hDEAD_0000 | i;
            busy      <= 1'b0;
            lat_cnt   <= 0;
            bus_rdata <= '0;
        end else if (bus_req) begin
            req_cnt   <= req_cnt + 1;
            busy      <= 1'b1;
            lat_cnt   <= LAT;
            p_addr    <= bus_addr;
            p_we      <= bus_we;
            p_wd      <= bus_wdata;
            last_addr <= bus_addr;
            last_we   <= bus_we;
        end else if (busy) begin
            if (lat_cnt == 1) begin
                bus_ack   <= 1'b1;
                bus_rdata <= mem[p_addr[3:0]];
                if (p_we) mem[p_addr[3:0]] <= p_wd;
                busy <= 1'b0;
            end
            lat_cnt <= lat_cnt - 1;
        end
    end

    function automatic logic [31:0] enc(input logic [1:0] f, input logic [31:0] w);
        logic [31:0] s;
        int bi, ti;
        for (int k = 0; k < 32; k++) begin
            bi = f[0] ? 3 - k / 8 : k / 8;
            ti = f[1] ? k % 8 : 7 - k % 8;
            s[31 - k] = w[bi * 8 + ti];
        end
        return s;
    endfunction

    function automatic logic [31:0] dec(input logic [1:0] f, input logic [31:0] s);
        logic [31:0] w;
        int bi, ti;
        for (int k = 0; k < 32; k++) begin
            bi = f[0] ? 3 - k / 8 : k / 8;
            ti = f[1] ? k % 8 : 7 - k % 8;
            w[bi * 8 + ti] = s[31 - k];
        end
        return w;
    endfunction

    function automatic logic [31:0] cfg_exp(input logic late, input int pad);
        return {8'd2, 7'd0, late, 12'd0, 4'(pad)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [22:0] addr, input logic [31:0] wd,
                        input int limit, output logic [31:0] raw);
        logic [23:0] cmd;
        logic [31:0] ws;
        int nb;
        int dstart;
        cmd    = {wr, addr};
        ws     = enc(cur_fmt, wd);
        dstart = 24 + 8 * cur_pad;
        nb     = wr ? 56 : dstart + 32;
        if (limit < nb) nb = limit;
        raw = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            if (b < 24) mosi = cmd[23 - b];
            else if (wr) mosi = ws[31 - (b - 24)];
            else mosi = 1'b0;
            repeat (H) @(negedge clk);
            if (!wr && b >= dstart) raw[31 - (b - dstart)] = miso;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (LAT + 20) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [22:0] addr, input logic [31:0] w);
        logic [31:0] dummy;
        xfer(1'b1, addr, w, 1000, dummy);
    endtask

    task automatic rd_reg(input logic [22:0] addr, output logic [31:0] raw);
        xfer(1'b0, addr, 32'h0, 1000, raw);
    endtask

    function automatic logic [31:0] repl(input logic [1:0] f);
        logic [7:0] b;
        b = {f[0], f[1], 4'b0000, f[1], f[0]};
        return {4{b}};
    endfunction

    task automatic set_fmt(input logic [1:0] f);
        wr_reg(BASE, repl(f));
        cur_fmt = f;
    endtask

    task automatic set_pad(input int p);
        wr_reg(CFG, 32'(p));
        cur_pad = p;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] raw;
        logic [31:0] pat;
        int idx;
        int rc;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R9 reset state
        chk("R9 miso", {31'd0, miso}, 32'd0);
        chk("R9 bus_req", {31'd0, bus_req}, 32'd0);
        rd_reg(BASE, raw);
        chk("R9 R5 fmt default", dec(2'b00, raw), 32'd0);
        rd_reg(CFG, raw);
        chk("R9 R6 cfgstat default", dec(2'b00, raw), cfg_exp(1'b0, 0));

        // R6 padding count
        set_pad(1);
        rd_reg(CFG, raw);
        chk("R6 cfgstat pad1", dec(cur_fmt, raw), cfg_exp(1'b0, 1));

        // R1 R2 R3 R4 R5 sweep over formats and patterns
        for (int f = 0; f < 4; f++) begin
            set_fmt(2'(f));
            rd_reg(BASE, raw);
            chk("R5 fmt readback", dec(cur_fmt, raw), 32'(f));
            for (int j = 0; j < 4; j++) begin
                idx = f * 4 + j;
                pat = 32'(idx + 1) * 32'h9E37_79B1;
                wr_reg(23'h10 + 23'(idx), pat);
                chk("R2 bus write data", mem[idx], pat);
                chk("R1 write addr", {9'd0, last_addr}, {9'd0, 23'h10 + 23'(idx)});
                chk("R1 write flag", {31'd0, last_we}, 32'd1);
                rd_reg(23'h10 + 23'(idx), raw);
                chk("R4 raw miso stream", raw, enc(cur_fmt, pat));
                chk("R3 read word", dec(cur_fmt, raw), pat);
                chk("R1 read flag", {31'd0, last_we}, 32'd0);
            end
        end

        // R3 deeper padding
        set_pad(3);
        rd_reg(23'h13, raw);
        chk("R3 read pad3", dec(cur_fmt, raw), 32'(4) * 32'h9E37_79B1);
        rd_reg(CFG, raw);
        chk("R6 cfgstat pad3", dec(cur_fmt, raw), cfg_exp(1'b0, 3));

        // R7 late read with no padding
        set_fmt(2'b01);
        set_pad(0);
        rd_reg(23'h12, raw);
        chk("R7 late data zero", raw, 32'd0);
        rd_reg(CFG, raw);
        chk("R7 late flag set", dec(cur_fmt, raw), cfg_exp(1'b1, 0));
        rd_reg(BASE, raw);
        chk("R7 fmt read ok", dec(cur_fmt, raw), 32'd1);
        rd_reg(CFG, raw);
        chk("R7 flag sticky", dec(cur_fmt, raw), cfg_exp(1'b1, 0));
        set_pad(2);
        rd_reg(CFG, raw);
        chk("R7 flag cleared", dec(cur_fmt, raw), cfg_exp(1'b0, 2));
        rd_reg(23'h12, raw);
        chk("R7 padded read ok", dec(cur_fmt, raw), 32'(3) * 32'h9E37_79B1);

        // R10 local read makes no bus request
        rc = req_cnt;
        rd_reg(CFG, raw);
        chk("R10 no bus req", 32'(req_cnt), 32'(rc));

        // R8 aborted writes
        rc = req_cnt;
        begin
            logic [31:0] d;
            xfer(1'b1, 23'h15, 32'h1234_5678, 40, d);
            chk("R8 no bus req", 32'(req_cnt), 32'(rc));
            chk("R8 mem kept", mem[5], 32'(6) * 32'h9E37_79B1);
            xfer(1'b1, BASE, repl(2'b10), 55, d);
        end
        rd_reg(BASE, raw);
        chk("R8 fmt kept", dec(cur_fmt, raw), 32'd1);
        wr_reg(23'h15, 32'hCAFE_F00D);
        chk("R8 next frame ok", mem[5], 32'hCAFE_F00D);

        // R9 reset restores defaults
        set_fmt(2'b11);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_fmt = 2'b00;
        cur_pad = 0;
        repeat (3) @(negedge clk);
        rd_reg(BASE, raw);
        chk("R9 fmt after reset", dec(2'b00, raw), 32'd0);
        rd_reg(CFG, raw);
        chk("R9 cfgstat after reset", dec(2'b00, raw), cfg_exp(1'b0, 0));

        finish_run();
    end
endmodule